// File: doc/BRIEF.md
# Algorithmic Address Generator

This block holds an address register behind a small arithmetic unit and drives a group of output channels from it while a memory is under test. Each clock cycle the block takes one command that leaves the register alone, loads it, steps it up or down by one, adds or subtracts an operand, XORs it with an operand, or inverts every bit. Address sequences are therefore computed during the run, and no vector storage is needed. All arithmetic wraps modulo the register width.

A channel mask picks which output channels follow the address register. A channel whose mask bit is clear drives the matching bit of a static data input, so the rest of the card keeps working as plain outputs. For memories that take their address in two halves on shared pins, a multiplexed mode alternates between a row phase and a column phase every cycle. The row phase shows the lower half of the register on the low channels, and the column phase shows the upper half there. A three-state phase machine (DIRECT, ROW, COLUMN) controls this mode.

Phase machine transitions, sampled at each rising clock edge: any state goes to DIRECT when the multiplex enable is low. When the enable is high, DIRECT goes to ROW, ROW goes to COLUMN and COLUMN goes to ROW. Reset puts the machine in DIRECT.

Top module: `addr_pattern_gen`

## Requirements
- R1: An active-low asynchronous reset clears the address register to zero and puts the phase machine in DIRECT. Commands presented while reset is held have no effect.
- R2: Opcode 3'd0 (hold) leaves the register unchanged. Opcode 3'd1 (load) copies the operand into the register.
- R3: Opcode 3'd2 adds one to the register and opcode 3'd3 subtracts one. Both wrap modulo 2^NCH, so all-ones plus one gives zero and zero minus one gives all-ones.
- R4: Opcode 3'd4 adds the operand to the register and opcode 3'd5 subtracts the operand from the register. Both wrap modulo 2^NCH.
- R5: Opcode 3'd6 XORs the register with the operand. Opcode 3'd7 inverts every register bit.
- R6: A command changes the register at the rising clock edge that ends the cycle in which it was presented. During that cycle the outputs still show the previous register value.
- R7: Output channel i drives presented-address bit i when mask bit i is 1, and bit i of the static input when mask bit i is 0. The mask and the static input act combinationally.
- R8: In DIRECT the presented address is the full register, with bit i on channel i. In ROW it is the register's lower NCH/2 bits on channels [NCH/2-1:0]. In COLUMN it is the register's upper bits on those same channels. In ROW and COLUMN the presented bits on channels [NCH-1:NCH/2] are zero. A high multiplex enable moves DIRECT to ROW at the next edge, and then ROW and COLUMN alternate every edge.
- R9: A low multiplex enable at a rising edge returns the phase machine to DIRECT from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_code | input | 3 | Command for this cycle (see R2 to R5) |
| operand | input | NCH | Operand for load, add, subtract and XOR |
| chan_mask | input | NCH | 1 = channel follows the address, 0 = channel follows static input |
| static_in | input | NCH | Data for channels not assigned to the address |
| mux_en | input | 1 | Enables row/column time multiplexing |
| ch_out | output | NCH | Output channel values |

## Verification
The bench drives the register across carry and borrow boundaries and through all-ones and zero in both directions. A design with a wrong adder width or a missing wrap would show a stray carry bit or a value that never passes through zero. It checks the outputs before the clock edge, so a design that shows the updated value early fails the R6 check. In multiplexed mode it checks which half reaches which phase and that the upper channels go to zero. It also checks the one-cycle delay before ROW, the mask mix inside a phase, and the return to DIRECT. A design with swapped halves, a stuck phase or an immediate mode switch gives the wrong word at one of these points.

// File: rtl/apg_pkg.sv
package apg_pkg;

    typedef enum logic [2:0] {
        OP_HOLD = 3'd0,
        OP_LOAD = 3'd1,
        OP_INC  = 3'd2,
        OP_DEC  = 3'd3,
        OP_ADD  = 3'd4,
        OP_SUB  = 3'd5,
        OP_XOR  = 3'd6,
        OP_INV  = 3'd7
    } apg_op_e;

    typedef enum logic [1:0] {
        PH_DIRECT = 2'd0,
        PH_ROW    = 2'd1,
        PH_COL    = 2'd2
    } apg_phase_e;

endpackage

// File: rtl/apg_alu.sv
module apg_alu
    import apg_pkg::*;
#(
    parameter int W = 24
) (
    input  apg_op_e        op,
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   opnd,
    output logic [W-1:0]   result
);

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (op)
            OP_HOLD: result = acc;
            OP_LOAD: result = opnd;
            OP_INC:  result = acc + ONE;
            OP_DEC:  result = acc - ONE;
            OP_ADD:  result = acc + opnd;
            OP_SUB:  result = acc - opnd;
            OP_XOR:  result = acc ^ opnd;
            OP_INV:  result = ~acc;
            default: result = acc;
        endcase
    end

endmodule

// File: rtl/apg_phase_fsm.sv
module apg_phase_fsm
    import apg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mux_en,
    output apg_phase_e phase,
    output logic       sel_row,
    output logic       sel_col
);

    apg_phase_e phase_q;
    apg_phase_e phase_d;

    // Next-state selection
    always_comb begin
        phase_d = PH_DIRECT;
        if (mux_en) begin
            unique case (phase_q)
                PH_DIRECT: phase_d = PH_ROW;
                PH_ROW:    phase_d = PH_COL;
                PH_COL:    phase_d = PH_ROW;
                default:   phase_d = PH_DIRECT;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_DIRECT;
        end else begin
            phase_q <= phase_d;
        end
    end

    // State outputs
    always_comb begin
        sel_row = 1'b0;
        sel_col = 1'b0;
        unique case (phase_q)
            PH_DIRECT: ;
            PH_ROW:    sel_row = 1'b1;
            PH_COL:    sel_col = 1'b1;
            default:   ;
        endcase
    end

    assign phase = phase_q;

endmodule

// File: rtl/apg_chan_map.sv
module apg_chan_map #(
    parameter int NCH = 24
) (
    input  logic [NCH-1:0] addr,
    input  logic           sel_row,
    input  logic           sel_col,
    input  logic [NCH-1:0] chan_mask,
    input  logic [NCH-1:0] static_in,
    output logic [NCH-1:0] ch_out
);

    localparam int H_LO = NCH / 2;
    localparam int H_HI = NCH - H_LO;

    logic [NCH-1:0] shown;

    always_comb begin
        if (sel_row) begin
            shown = {{H_HI{1'b0}}, addr[H_LO-1:0]};
        end else if (sel_col) begin
            shown = {{H_LO{1'b0}}, addr[NCH-1:H_LO]};
        end else begin
            shown = addr;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign ch_out[i] = chan_mask[i] ? shown[i] : static_in[i];
    end

endmodule

// File: rtl/addr_pattern_gen.sv
module addr_pattern_gen
    import apg_pkg::*;
#(
    parameter int NCH = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     op_code,
    input  logic [NCH-1:0] operand,
    input  logic [NCH-1:0] chan_mask,
    input  logic [NCH-1:0] static_in,
    input  logic           mux_en,
    output logic [NCH-1:0] ch_out
);

    logic [NCH-1:0] addr_q;
    logic [NCH-1:0] addr_d;
    apg_phase_e     phase;
    logic           sel_row;
    logic           sel_col;

    apg_alu #(.W(NCH)) i_alu (
        .op     (apg_op_e'(op_code)),
        .acc    (addr_q),
        .opnd   (operand),
        .result (addr_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    apg_phase_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mux_en  (mux_en),
        .phase   (phase),
        .sel_row (sel_row),
        .sel_col (sel_col)
    );

    apg_chan_map #(.NCH(NCH)) i_map (
        .addr      (addr_q),
        .sel_row   (sel_row),
        .sel_col   (sel_col),
        .chan_mask (chan_mask),
        .static_in (static_in),
        .ch_out    (ch_out)
    );

endmodule

// File: rtl/apg_checker.sv
module apg_checker
    import apg_pkg::*;
#(
    parameter int NCH = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     op_code,
    input  logic [NCH-1:0] operand,
    input  logic [NCH-1:0] chan_mask,
    input  logic [NCH-1:0] static_in,
    input  logic           mux_en,
    input  logic [NCH-1:0] ch_out,
    input  logic [NCH-1:0] addr_q,
    input  apg_phase_e     phase
);

    localparam logic [NCH-1:0] ONE = NCH'(1);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (addr_q == '0 && phase == PH_DIRECT));

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd1) |=> (addr_q == $past(operand)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd0) |=> $stable(addr_q));

    p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd2) |=> (addr_q == $past(addr_q) + ONE));

    p_sub_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd5) |=> (addr_q == $past(addr_q) - $past(operand)));

    p_inv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 3'd7) |=> (addr_q == ~$past(addr_q)));

    p_static_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_out & ~chan_mask) == (static_in & ~chan_mask)));

    p_row_to_col_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_en && phase == PH_ROW) |=> (phase == PH_COL));

    p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_DIRECT) |-> ((ch_out & chan_mask) >> (NCH / 2) == '0));

    p_back_direct_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mux_en |=> (phase == PH_DIRECT));

endmodule

bind addr_pattern_gen apg_checker #(.NCH(NCH)) i_apg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .operand   (operand),
    .chan_mask (chan_mask),
    .static_in (static_in),
    .mux_en    (mux_en),
    .ch_out    (ch_out),
    .addr_q    (addr_q),
    .phase     (phase)
);

// File: tb/test_addr_pattern_gen.sv
module test_addr_pattern_gen;

    localparam int NCH = 24;
    localparam int NV  = 15;
    localparam int VW  = 3 + 4 * NCH;

    // Entry fields: op, operand, mask, static, expected output after the edge
    localparam logic [VW-1:0] VEC [NV] = '{
        {3'd1, 24'h00FFFE, 24'hFFFFFF, 24'h000000, 24'h00FFFE}, // R2 load
        {3'd2, 24'h000000, 24'hFFFFFF, 24'h000000, 24'h00FFFF}, // R3 inc
        {3'd2, 24'h000000, 24'hFFFFFF, 24'h000000, 24'h010000}, // R3 carry
        {3'd3, 24'h000000, 24'hFFFFFF, 24'h000000, 24'h00FFFF}, // R3 borrow
        {3'd4, 24'h000101, 24'hFFFFFF, 24'h000000, 24'h010100}, // R4 add
        {3'd5, 24'h010200, 24'hFFFFFF, 24'h000000, 24'hFFFF00}, // R4 sub wrap
        {3'd6, 24'h0F0F0F, 24'hFFFFFF, 24'h000000, 24'hF0F00F}, // R5 xor
        {3'd7, 24'h000000, 24'hFFFFFF, 24'h000000, 24'h0F0FF0}, // R5 inv
        {3'd0, 24'h123456, 24'hFFFFFF, 24'h000000, 24'h0F0FF0}, // R2 hold
        {3'd1, 24'hFFFFFF, 24'hFFFFFF, 24'h000000, 24'hFFFFFF}, // R2 load ones
        {3'd2, 24'h000000, 24'hFFFFFF, 24'h000000, 24'h000000}, // R3 wrap up
        {3'd3, 24'h000000, 24'hFFFFFF, 24'h000000, 24'hFFFFFF}, // R3 wrap down
        {3'd0, 24'h000000, 24'h00FF00, 24'h5A5A5A, 24'h5AFF5A}, // R7 mix
        {3'd1, 24'h123456, 24'h000000, 24'hA5A5A5, 24'hA5A5A5}, // R7 all static
        {3'd0, 24'h000000, 24'hFFFFFF, 24'h000000, 24'h123456}  // R7 all address
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     op_code = 3'd0;
    logic [NCH-1:0] operand = '0;
    logic [NCH-1:0] chan_mask = '1;
    logic [NCH-1:0] static_in = '0;
    logic           mux_en = 1'b0;
    logic [NCH-1:0] ch_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    addr_pattern_gen #(.NCH(NCH)) i_addr_pattern_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_code   (op_code),
        .operand   (operand),
        .chan_mask (chan_mask),
        .static_in (static_in),
        .mux_en    (mux_en),
        .ch_out    (ch_out)
    );

    task automatic check(input string req, input logic [NCH-1:0] act,
                         input logic [NCH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ch_out=%06h expected %06h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [NCH-1:0] opnd,
                         input logic [NCH-1:0] msk, input logic [NCH-1:0] st,
                         input logic mx);
        op_code   = op;
        operand   = opnd;
        chan_mask = msk;
        static_in = st;
        mux_en    = mx;
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state and commands ignored under reset
        drive(3'd1, 24'h111111, 24'hFFFFFF, 24'h000000, 1'b0);
        repeat (3) step();
        check("R1 reset clears", ch_out, 24'h000000);
        drive(3'd1, 24'h111111, 24'h000000, 24'h5A5A5A, 1'b0);
        #1;
        check("R1 static in reset", ch_out, 24'h5A5A5A);
        drive(3'd0, 24'h000000, 24'hFFFFFF, 24'h000000, 1'b0);
        rst_n = 1'b1;
        step();
        check("R1 after release", ch_out, 24'h000000);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            logic [VW-1:0] v;
            v = VEC[k];
            drive(v[VW-1 -: 3], v[4*NCH-1 -: NCH], v[3*NCH-1 -: NCH],
                  v[2*NCH-1 -: NCH], 1'b0);
            step();
            check($sformatf("R2-table entry %0d", k), ch_out, v[NCH-1:0]);
        end

        // R6: old value visible before edge
        drive(3'd1, 24'hABC123, 24'hFFFFFF, 24'h000000, 1'b0);
        #1;
        check("R6 pre-edge old value", ch_out, 24'h123456);
        step();
        check("R6 post-edge load", ch_out, 24'hABC123);

        // R8: multiplexed phases
        drive(3'd0, 24'h000000, 24'hFFFFFF, 24'h000000, 1'b1);
        #1;
        check("R8 enable delayed one cycle", ch_out, 24'hABC123);
        step();
        check("R8 row phase low half", ch_out, 24'h000123);
        step();
        check("R8 column phase high half", ch_out, 24'h000ABC);
        drive(3'd0, 24'h000000, 24'h000FFF, 24'hF00000, 1'b1);
        step();
        check("R8 R7 row with static upper", ch_out, 24'hF00123);
        drive(3'd2, 24'h000000, 24'hFFFFFF, 24'h000000, 1'b1);
        #1;
        check("R6 R8 pre-edge row old value", ch_out, 24'h000123);
        step();
        check("R8 column after inc", ch_out, 24'h000ABC);

        // R9: back to direct
        drive(3'd0, 24'h000000, 24'hFFFFFF, 24'h000000, 1'b0);
        step();
        check("R9 direct restored", ch_out, 24'hABC124);
        drive(3'd3, 24'h000000, 24'hFFFFFF, 24'h000000, 1'b0);
        step();
        check("R3 dec in direct", ch_out, 24'hABC123);

        // R1: asynchronous reset in the middle of multiplexing
        drive(3'd0, 24'h000000, 24'hFFFFFF, 24'h000000, 1'b1);
        step();
        check("R8 row before reset", ch_out, 24'h000123);
        rst_n = 1'b0;
        #1;
        check("R1 async clear", ch_out, 24'h000000);
        drive(3'd1, 24'h000456, 24'hFFFFFF, 24'h000000, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        check("R1 R2 load after reset direct", ch_out, 24'h000456);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule